// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers twenty-eight interrupt request lines, three of them external level inputs and the rest from on-chip peripherals such as timers, DMA channels, serial ports, the real-time clock, the watchdog and the memory-refresh unit. Each peripheral source takes a 4-bit priority from one nibble of three 16-bit priority registers, and several sources can share one nibble. The three external lines have fixed priorities. A source is eligible when its request line is high and its enable bit is set. The controller picks the eligible source with the highest priority and compares that priority with the processor's current mask level and block bit.

When the winning source is acceptable, the controller raises a valid output and shows that source's 12-bit event code. It pulses a one-cycle accept strobe each time a new winner appears. Acceptance does not clear requests. Each peripheral holds its request line until its own handler clears it. Software programs the priorities, the per-source enables and a spare control register through a small write/read register port.

Top module: `prio_intc`

## Requirements
- R1: After reset, the control register and the three priority registers read 0x0000, both enable registers read back all enables set (0xFFFF at 0x10, 0x0FFF at 0x14), and `irq_valid_o` and `irq_accept_o` are low.
- R2: Byte offsets 0x00 (control), 0x04 (priority A), 0x08 (priority B) and 0x0C (priority C) read back the last 16-bit value written to them.
- R3: Nibble n of a priority register sits at bits 4n+3..4n. The source assignments are: timer0 underflow (0x400) from A nibble 3; serial-1 requests (0x4E0, 0x500, 0x520, 0x540) from B nibble 1; DMA end and DMA error requests (0x640 to 0x6C0) from C nibble 2; the other sources as listed in the package table.
- R4: External lines 9, 11 and 13 (codes 0x320, 0x360 and 0x3A0) have fixed priorities 6, 4 and 2.
- R5: A source is accepted only if its request is high, it is enabled, and its priority is strictly greater than `cpu_mask_i`. A mask of 15 accepts nothing.
- R6: While `cpu_block_i` is high, no request is accepted.
- R7: A source whose priority is 0 is never accepted.
- R8: The highest priority wins. Among equal priorities, the source with the larger index in the fixed source order wins (the order is given in the package table; DMA error at index 9 and timer0 at index 10).
- R9: Enable bits for sources 15..0 sit at offset 0x10, bits 15..0. Enable bits for sources 27..16 sit at offset 0x14, bits 11..0. A cleared bit removes that source from arbitration.
- R10: `irq_accept_o` pulses for one cycle when `irq_valid_o` rises or when the winning code changes. It stays low while the same winner is still accepted. A held request stays valid after it is accepted.
- R11: Writing a priority register with the value it already holds causes no new accept pulse. Writing a different value re-arbitrates with the new priority.
- R12: The outputs reflect the inputs sampled at the previous rising clock edge. A register write takes effect on the outputs one cycle after the write is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | 28 | Level request per source, in the fixed source order |
| cpu_mask_i | input | 4 | Processor interrupt mask level |
| cpu_block_i | input | 1 | Processor block bit; holds off all requests |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` (combinational) |
| irq_valid_o | output | 1 | An acceptable interrupt is being presented |
| irq_code_o | output | 12 | Event code of the winning source |
| irq_accept_o | output | 1 | One-cycle pulse when a new winner is accepted |

## Verification
Some rules hold on every cycle, and the assertions check those. A set block bit, a mask of 15 or an idle request vector leaves nothing valid on the following cycle. The accept pulse only comes with a valid output and a new or changed winner, and it never repeats for a held, unchanged winner. The bench scenarios cover the rest. They check how register nibbles map to sources, the fixed external priorities, strict comparison against the mask, equal-priority resolution by source index, the enable registers, and how equal and differing priority writes behave.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC    = 28;
    localparam int PW      = 4;
    localparam int CW      = 12;
    localparam int RW      = 16;
    localparam int AW      = 5;
    localparam int NPREG   = 3;
    localparam int EN_HI_W = NSRC - RW;

    localparam logic [AW-1:0] OFS_CTRL  = 5'h00;
    localparam logic [AW-1:0] OFS_PRA   = 5'h04;
    localparam logic [AW-1:0] OFS_PRB   = 5'h08;
    localparam logic [AW-1:0] OFS_PRC   = 5'h0C;
    localparam logic [AW-1:0] OFS_EN_LO = 5'h10;
    localparam logic [AW-1:0] OFS_EN_HI = 5'h14;

    // Where a source takes its priority from
    typedef enum logic [1:0] {
        SEL_FIX = 2'd0,
        SEL_A   = 2'd1,
        SEL_B   = 2'd2,
        SEL_C   = 2'd3
    } prio_sel_e;

    typedef struct packed {
        prio_sel_e     sel;
        logic [1:0]    nib;
        logic [PW-1:0] fixed;
        logic [CW-1:0] code;
    } src_desc_t;

    typedef struct packed {
        logic          valid;
        logic [CW-1:0] code;
    } winner_t;

    function automatic src_desc_t mk(prio_sel_e s, int n, int f, int c);
        src_desc_t d;
        d.sel   = s;
        d.nib   = 2'(n);
        d.fixed = PW'(f);
        d.code  = CW'(c);
        return d;
    endfunction

    // Fixed source order; index decides equal-priority ties (larger wins)
    function automatic src_desc_t src_desc(int idx);
        case (idx)
            0:  return mk(SEL_FIX, 0, 15 - 9,  'h320);
            1:  return mk(SEL_FIX, 0, 15 - 11, 'h360);
            2:  return mk(SEL_FIX, 0, 15 - 13, 'h3A0);
            3:  return mk(SEL_C, 0, 0, 'h600);
            4:  return mk(SEL_C, 3, 0, 'h620);
            5:  return mk(SEL_C, 2, 0, 'h640);
            6:  return mk(SEL_C, 2, 0, 'h660);
            7:  return mk(SEL_C, 2, 0, 'h680);
            8:  return mk(SEL_C, 2, 0, 'h6A0);
            9:  return mk(SEL_C, 2, 0, 'h6C0);
            10: return mk(SEL_A, 3, 0, 'h400);
            11: return mk(SEL_A, 2, 0, 'h420);
            12: return mk(SEL_A, 1, 0, 'h440);
            13: return mk(SEL_A, 1, 0, 'h460);
            14: return mk(SEL_A, 0, 0, 'h480);
            15: return mk(SEL_A, 0, 0, 'h4A0);
            16: return mk(SEL_A, 0, 0, 'h4C0);
            17: return mk(SEL_B, 1, 0, 'h4E0);
            18: return mk(SEL_B, 1, 0, 'h500);
            19: return mk(SEL_B, 1, 0, 'h520);
            20: return mk(SEL_B, 1, 0, 'h540);
            21: return mk(SEL_C, 1, 0, 'h700);
            22: return mk(SEL_C, 1, 0, 'h720);
            23: return mk(SEL_C, 1, 0, 'h740);
            24: return mk(SEL_C, 1, 0, 'h760);
            25: return mk(SEL_B, 3, 0, 'h560);
            26: return mk(SEL_B, 2, 0, 'h580);
            default: return mk(SEL_A, 2, 0, 'h5A0);
        endcase
    endfunction

endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_i,
    input  logic [AW-1:0]              addr_i,
    input  logic [RW-1:0]              wdata_i,
    output logic [RW-1:0]              rdata_o,
    output logic [NPREG-1:0][RW-1:0]   prio_regs_o,
    output logic [NSRC-1:0]            en_o
);

    logic [RW-1:0]            ctrl_q;
    logic [NPREG-1:0][RW-1:0] prio_q;
    logic [NSRC-1:0]          en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            prio_q <= '0;
            en_q   <= '1;
        end else if (wr_i) begin
            case (addr_i)
                OFS_CTRL:  ctrl_q    <= wdata_i;
                OFS_PRA:   prio_q[0] <= wdata_i;
                OFS_PRB:   prio_q[1] <= wdata_i;
                OFS_PRC:   prio_q[2] <= wdata_i;
                OFS_EN_LO: en_q[RW-1:0] <= wdata_i;
                OFS_EN_HI: en_q[NSRC-1:RW] <= wdata_i[EN_HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr_i)
            OFS_CTRL:  rdata_o = ctrl_q;
            OFS_PRA:   rdata_o = prio_q[0];
            OFS_PRB:   rdata_o = prio_q[1];
            OFS_PRC:   rdata_o = prio_q[2];
            OFS_EN_LO: rdata_o = en_q[RW-1:0];
            OFS_EN_HI: rdata_o = {{(RW-EN_HI_W){1'b0}}, en_q[NSRC-1:RW]};
            default:   rdata_o = '0;
        endcase
    end

    assign prio_regs_o = prio_q;
    assign en_o        = en_q;

endmodule

// File: rtl/intc_prio_map.sv
module intc_prio_map
    import intc_pkg::*;
(
    input  logic [NPREG-1:0][RW-1:0]  prio_regs_i,
    output logic [NSRC-1:0][PW-1:0]   prio_o,
    output logic [NSRC-1:0][CW-1:0]   code_o
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam src_desc_t D = src_desc(i);
        assign code_o[i] = D.code;
        if (D.sel == SEL_FIX) begin : g_fix
            assign prio_o[i] = D.fixed;
        end else begin : g_reg
            localparam int RIDX = int'(D.sel) - 1;
            localparam int LSB  = int'(D.nib) * PW;
            assign prio_o[i] = prio_regs_i[RIDX][LSB +: PW];
        end
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
(
    input  logic [NSRC-1:0]           req_i,
    input  logic [NSRC-1:0]           en_i,
    input  logic [NSRC-1:0][PW-1:0]   prio_i,
    input  logic [NSRC-1:0][CW-1:0]   code_i,
    input  logic [PW-1:0]             mask_i,
    input  logic                      block_i,
    output winner_t                   win_o
);

    logic [NSRC-1:0] elig;
    logic [PW-1:0]   best_p;

    for (genvar i = 0; i < NSRC; i++) begin : g_elig
        assign elig[i] = req_i[i] && en_i[i] && (prio_i[i] > mask_i) && !block_i;
    end

    // Ascending scan with >= so a later index takes equal-priority ties
    always_comb begin
        best_p      = '0;
        win_o.valid = 1'b0;
        win_o.code  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!win_o.valid || prio_i[i] >= best_p)) begin
                win_o.valid = 1'b1;
                best_p      = prio_i[i];
                win_o.code  = code_i[i];
            end
        end
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      src_req_i,
    input  logic [PW-1:0]        cpu_mask_i,
    input  logic                 cpu_block_i,
    input  logic                 reg_wr_i,
    input  logic [AW-1:0]        reg_addr_i,
    input  logic [RW-1:0]        reg_wdata_i,
    output logic [RW-1:0]        reg_rdata_o,
    output logic                 irq_valid_o,
    output logic [CW-1:0]        irq_code_o,
    output logic                 irq_accept_o
);

    logic [NPREG-1:0][RW-1:0] prio_regs;
    logic [NSRC-1:0]          en;
    logic [NSRC-1:0][PW-1:0]  prio;
    logic [NSRC-1:0][CW-1:0]  codes;
    winner_t                  win;
    winner_t                  out_q;
    logic                     stb_q;

    intc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .prio_regs_o(prio_regs),
        .en_o       (en)
    );

    intc_prio_map u_map (
        .prio_regs_i(prio_regs),
        .prio_o     (prio),
        .code_o     (codes)
    );

    intc_arbiter u_arb (
        .req_i  (src_req_i),
        .en_i   (en),
        .prio_i (prio),
        .code_i (codes),
        .mask_i (cpu_mask_i),
        .block_i(cpu_block_i),
        .win_o  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            stb_q <= 1'b0;
        end else begin
            out_q <= win;
            stb_q <= win.valid && (!out_q.valid || (win.code != out_q.code));
        end
    end

    assign irq_valid_o  = out_q.valid;
    assign irq_code_o   = out_q.code;
    assign irq_accept_o = stb_q;

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import intc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NSRC-1:0]      src_req_i,
    input logic [PW-1:0]        cpu_mask_i,
    input logic                 cpu_block_i,
    input logic                 reg_wr_i,
    input logic [AW-1:0]        reg_addr_i,
    input logic [RW-1:0]        reg_wdata_i,
    input logic [RW-1:0]        reg_rdata_o,
    input logic                 irq_valid_o,
    input logic [CW-1:0]        irq_code_o,
    input logic                 irq_accept_o
);

    assert_block_holds_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_block_i |=> !irq_valid_o);

    assert_mask_top_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_mask_i == 4'hF) |=> !irq_valid_o);

    assert_no_req_R5: assert property (@(posedge clk) disable iff (rst)
        (src_req_i == '0) |=> !irq_valid_o);

    assert_accept_valid_R10: assert property (@(posedge clk) disable iff (rst)
        irq_accept_o |-> irq_valid_o);

    assert_accept_new_R10: assert property (@(posedge clk) disable iff (rst)
        irq_accept_o |-> (!$past(irq_valid_o) || ($past(irq_code_o) != irq_code_o)));

    assert_no_repeat_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_valid_o && $past(irq_valid_o) && $stable(irq_code_o)) |-> !irq_accept_o);

endmodule

bind prio_intc prio_intc_chk u_chk (.*);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    import intc_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NSRC-1:0]      src_req_i = '0;
    logic [PW-1:0]        cpu_mask_i = '0;
    logic                 cpu_block_i = 1'b0;
    logic                 reg_wr_i = 1'b0;
    logic [AW-1:0]        reg_addr_i = '0;
    logic [RW-1:0]        reg_wdata_i = '0;
    logic [RW-1:0]        reg_rdata_o;
    logic                 irq_valid_o;
    logic [CW-1:0]        irq_code_o;
    logic                 irq_accept_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit          chk;
        bit          v;
        logic [11:0] code;
        bit          stb;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t e;

    always #2 clk = ~clk;

    prio_intc u_prio_intc (.*);

    // Monitor: one expectation per rising edge, compared 1 ns after it
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            if (e.chk) begin
                checks++;
                if (irq_valid_o !== e.v || irq_accept_o !== e.stb ||
                    (e.v && irq_code_o !== e.code)) begin
                    errors++;
                    $display("FAIL %s: got valid=%0b code=%03h stb=%0b, exp valid=%0b code=%03h stb=%0b",
                             e.tag, irq_valid_o, irq_code_o, irq_accept_o, e.v, e.code, e.stb);
                end
            end
        end
    end

    // Driver: inputs already set at this falling edge; outcome due at next rising edge
    task automatic cyc(bit v, logic [11:0] code, bit stb, string tag);
        exp_t x;
        x.chk = 1'b1; x.v = v; x.code = code; x.stb = stb; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        exp_t x;
        x.chk = 1'b0; x.v = 1'b0; x.code = '0; x.stb = 1'b0; x.tag = "";
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        q.push_back(x);
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic [15:0] exp, string tag);
        reg_addr_i = a;
        #1;
        checks++;
        if (reg_rdata_o !== exp) begin
            errors++;
            $display("FAIL %s: read %02h got %04h exp %04h", tag, a, reg_rdata_o, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(5'h00, 16'h0000, "R1 ctrl");
        rd(5'h04, 16'h0000, "R1 prio A");
        rd(5'h08, 16'h0000, "R1 prio B");
        rd(5'h0C, 16'h0000, "R1 prio C");
        rd(5'h10, 16'hFFFF, "R1 R9 enable low");
        rd(5'h14, 16'h0FFF, "R1 R9 enable high");
        cyc(0, 12'h000, 0, "R1 idle after reset");

        // R4 fixed line 9, R12 one-cycle latency, R10 held request
        src_req_i = 28'h1;
        cyc(1, 12'h320, 1, "R4 R12 line9 accepted");
        cyc(1, 12'h320, 0, "R10 held, no second pulse");
        // R5 strict compare
        cpu_mask_i = 4'd5;
        cyc(1, 12'h320, 0, "R5 prio6 over mask5");
        cpu_mask_i = 4'd6;
        cyc(0, 12'h000, 0, "R5 prio6 equal mask6");
        cpu_mask_i = 4'd0;
        cyc(1, 12'h320, 1, "R10 re-accept after drop");

        // R8 highest wins, R10 new winner pulse
        src_req_i = 28'h3;
        cyc(1, 12'h320, 0, "R8 prio6 beats prio4");
        src_req_i = 28'h2;
        cyc(1, 12'h360, 1, "R10 R4 new winner line11");

        // R6 block
        cpu_block_i = 1'b1;
        cyc(0, 12'h000, 0, "R6 block holds off");
        cpu_block_i = 1'b0;
        cyc(1, 12'h360, 1, "R6 release");

        // R7 zero priority, R3 nibble 3 of A
        src_req_i = 28'h2 | (28'h1 << 10);
        cyc(1, 12'h360, 0, "R7 timer0 prio0 ignored");
        wr(5'h04, 16'h7000);
        cyc(1, 12'h400, 1, "R3 R12 timer0 from A nibble3");
        rd(5'h04, 16'h7000, "R2 prio A readback");

        // R8 tie: DMA (C nibble2) at 7 ties with timer0
        wr(5'h0C, 16'h0700);
        src_req_i = 28'h2 | (28'h1 << 5) | (28'h1 << 9) | (28'h1 << 10);
        cyc(1, 12'h400, 0, "R8 tie, index10 wins");
        src_req_i = 28'h2 | (28'h1 << 5) | (28'h1 << 9);
        cyc(1, 12'h6C0, 1, "R8 R3 tie, index9 over index5");

        // R9 enable
        wr(5'h10, 16'hFDFF);
        cyc(1, 12'h640, 1, "R9 disabled src9");
        rd(5'h10, 16'hFDFF, "R9 enable readback");

        // R11 equal then differing write
        wr(5'h0C, 16'h0700);
        cyc(1, 12'h640, 0, "R11 identical write");
        wr(5'h0C, 16'h0300);
        cyc(1, 12'h360, 1, "R11 lowered DMA prio");

        // R3 serial-1 from B nibble 1
        wr(5'h08, 16'h00A0);
        src_req_i = 28'h2 | (28'h1 << 20);
        cyc(1, 12'h540, 1, "R3 serial1 from B nibble1");
        rd(5'h08, 16'h00A0, "R2 prio B readback");

        // R5 mask 15
        cpu_mask_i = 4'hF;
        cyc(0, 12'h000, 0, "R5 mask15 blocks prio10");

        // R7 zero priority with mask 0
        wr(5'h04, 16'h0000);
        cpu_mask_i = 4'd0;
        src_req_i = 28'h1 << 10;
        cyc(0, 12'h000, 0, "R7 prio0 never taken");

        // R4 line13 priority 2
        src_req_i = 28'h4;
        cpu_mask_i = 4'd1;
        cyc(1, 12'h3A0, 1, "R4 line13 over mask1");
        cpu_mask_i = 4'd2;
        cyc(0, 12'h000, 0, "R4 R5 line13 at mask2");

        // R12 one-cycle pulse tracked exactly
        cpu_mask_i = 4'd0;
        src_req_i = 28'h1;
        cyc(1, 12'h320, 1, "R12 pulse in");
        src_req_i = '0;
        cyc(0, 12'h000, 0, "R12 pulse out");

        // R2 control register
        wr(5'h00, 16'hBEEF);
        rd(5'h00, 16'hBEEF, "R2 ctrl readback");
        rd(5'h14, 16'h0FFF, "R9 enable high unchanged");

        @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule